// File: doc/BRIEF.md
# Line latch with polarity output control

This block sits between a column data register and the per-column gray-scale converters of a display source driver. Once per horizontal line a strobe is pulsed; on its rising edge the block copies every 6-bit column code from the data register into a line latch and captures the polarity input. While the strobe stays high every column output is disconnected, and from its falling edge onwards the freshly latched codes are driven.

For every column the block also chooses the reference bank. With the captured polarity, odd and even columns always land on opposite banks, so the panel sees column inversion without any help from the common electrode. Each column gets a tap index on one unified ladder ordered from the highest reference voltage (0) to the lowest. In the upper bank, code 0 is the top of the ladder. In the lower bank, code 0 is the bottom. The analog ladder and the output amplifiers are outside this block.

The data register side has no valid/ready handshake and no back-pressure: the block takes whatever the register holds at the strobe's rising edge, and the upstream shifter must have finished loading before that edge. The strobe, polarity and enables are plain level signals sampled on `clk`.

Top module: `linelat_pol_ctl`

## Requirements
- R1: At the first `clk` edge that samples `line_stb` high after a cycle in which it was low, `lat_codes` takes the value of `col_codes`, and this is visible after that edge. At all other edges `lat_codes` holds, whatever `col_codes` does. Column c occupies bits [c*CW +: CW].
- R2: After any `clk` edge that samples `line_stb` high, `col_oe` is all zeros.
- R3: After an edge that samples `line_stb` low, `col_oe` is all ones, provided a strobe pulse has completed since reset.
- R4: `bank_sel[c]` is the captured polarity XOR (c odd), where column index c = 0 is the first (odd-numbered) column. The value 0 selects the upper bank and 1 selects the lower bank. Adjacent columns therefore always select opposite banks.
- R5: The polarity is captured only at the strobe's rising edge, and a later change of `pol_in` leaves `bank_sel` unchanged until the next rising edge.
- R6: `ref_tap` for column c occupies bits [c*(CW+1) +: CW+1]. It equals the code for the upper bank, and 2^(CW+1)-1 minus the code for the lower bank. This gives 0 = highest reference and 127 = lowest when CW = 6.
- R7: The strobe must stay high for at least 2 clock edges; a shorter pulse is a protocol error reported by the checker.
- R8: While `rst_n` is low, and after it is released until the first strobe pulse has ended, `col_oe` is zero. Reset clears the latch to zero and the captured polarity to 0, which gives `bank_sel` = alternating 0,1,... from column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb | input | 1 | Line strobe, one pulse per line, at least 2 clocks high |
| pol_in | input | 1 | Polarity, captured at the strobe's rising edge |
| col_codes | input | NCOL*CW | Codes from the column data register |
| lat_codes | output | NCOL*CW | Latched column codes |
| bank_sel | output | NCOL | Per-column bank, 0 upper, 1 lower |
| ref_tap | output | NCOL*(CW+1) | Per-column tap on the unified ladder |
| col_oe | output | NCOL | Per-column output enable, 0 = high impedance |

## Verification
The line sequence is run with all-zero codes, all-ones codes and mixed patterns, under both polarities. The all-zero and all-ones patterns separate the two ends of each bank's mapping, and the mixed patterns expose swapped or misplaced column fields. Between lines the bench flips the polarity and scrambles the data register while the strobe is low; this separates a true edge capture from a transparent path. Strobe widths of 2 and 4 clocks show that the enable follows the strobe level rather than a fixed count. A reset asserted in the middle of a line shows that the outputs are cleared and stay disconnected until a complete pulse has passed.

// File: rtl/linelat_pkg.sv
package linelat_pkg;
  typedef enum logic {
    BANK_UPPER = 1'b0,
    BANK_LOWER = 1'b1
  } bank_e;

  // Odd-numbered columns (even index) follow the polarity; the others take the opposite bank.
  function automatic bank_e bank_for(input logic pol, input int col_idx);
    return bank_e'(pol ^ ((col_idx % 2) == 1));
  endfunction
endpackage

// File: rtl/linelat_stb_seq.sv
module linelat_stb_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic line_stb,
  output logic stb_rise,
  output logic drive_en
);
  logic stb_q;
  logic primed_q;
  logic en_q;

  assign stb_rise = line_stb & ~stb_q;
  assign drive_en = en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q    <= 1'b0;
      primed_q <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      stb_q <= line_stb;
      if (stb_rise) primed_q <= 1'b1;
      en_q <= primed_q & ~line_stb;
    end
  end
endmodule

// File: rtl/linelat_store.sv
module linelat_store #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] d_in,
  input  logic         pol_d,
  output logic [W-1:0] q,
  output logic         pol_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      pol_q <= 1'b0;
    end else if (cap) begin
      q     <= d_in;
      pol_q <= pol_d;
    end
  end
endmodule

// File: rtl/linelat_col_map.sv
module linelat_col_map
  import linelat_pkg::*;
#(
  parameter int NCOL = 8,
  parameter int CW   = 6
) (
  input  logic                   pol_q,
  input  logic [NCOL*CW-1:0]     codes,
  output logic [NCOL-1:0]        bank_sel,
  output logic [NCOL*(CW+1)-1:0] ref_tap
);
  localparam int TW = CW + 1;
  localparam logic [TW-1:0] TAP_LAST = {TW{1'b1}};

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    bank_e           bank;
    logic [CW-1:0]   code;
    assign code = codes[c*CW +: CW];
    assign bank = bank_for(pol_q, c);
    assign bank_sel[c] = bank;
    always_comb begin
      if (bank == BANK_LOWER) ref_tap[c*TW +: TW] = TAP_LAST - {1'b0, code};
      else                    ref_tap[c*TW +: TW] = {1'b0, code};
    end
  end
endmodule

// File: rtl/linelat_pol_ctl.sv
module linelat_pol_ctl #(
  parameter int NCOL = 8,
  parameter int CW   = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   line_stb,
  input  logic                   pol_in,
  input  logic [NCOL*CW-1:0]     col_codes,
  output logic [NCOL*CW-1:0]     lat_codes,
  output logic [NCOL-1:0]        bank_sel,
  output logic [NCOL*(CW+1)-1:0] ref_tap,
  output logic [NCOL-1:0]        col_oe
);
  localparam int DW = NCOL * CW;

  logic stb_rise;
  logic drive_en;
  logic pol_q;

  linelat_stb_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_stb (line_stb),
    .stb_rise (stb_rise),
    .drive_en (drive_en)
  );

  linelat_store #(.W(DW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (stb_rise),
    .d_in  (col_codes),
    .pol_d (pol_in),
    .q     (lat_codes),
    .pol_q (pol_q)
  );

  linelat_col_map #(.NCOL(NCOL), .CW(CW)) u_map (
    .pol_q    (pol_q),
    .codes    (lat_codes),
    .bank_sel (bank_sel),
    .ref_tap  (ref_tap)
  );

  assign col_oe = {NCOL{drive_en}};
endmodule

// File: rtl/linelat_chk.sv
module linelat_chk #(
  parameter int NCOL = 8,
  parameter int CW   = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               line_stb,
  input logic [NCOL*CW-1:0] col_codes,
  input logic [NCOL*CW-1:0] lat_codes,
  input logic [NCOL-1:0]    bank_sel,
  input logic [NCOL-1:0]    col_oe
);
  function automatic logic [NCOL-1:0] alt_mask();
    logic [NCOL-1:0] m;
    for (int i = 0; i < NCOL; i++) m[i] = (i % 2) == 1;
    return m;
  endfunction
  localparam logic [NCOL-1:0] ALT = alt_mask();

  logic       stb_prev;
  logic [1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_prev <= 1'b0;
      hi_cnt   <= '0;
    end else begin
      stb_prev <= line_stb;
      if (!line_stb)          hi_cnt <= '0;
      else if (hi_cnt != 2'd3) hi_cnt <= hi_cnt + 2'd1;
    end
  end

  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && !stb_prev) |=> (lat_codes == $past(col_codes)));

  a_r2_hiz_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    line_stb |=> (col_oe == '0));

  a_r3_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_prev && !line_stb) |=> (col_oe == '1));

  a_r4_opposite_banks: assert property (@(posedge clk) disable iff (!rst_n)
    (((bank_sel ^ ALT) == '0) || ((bank_sel ^ ALT) == '1)));

  a_r5_hold_between_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_stb && !stb_prev) |=> ($stable(bank_sel) && $stable(lat_codes)));

  a_r7_min_width: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_prev && !line_stb) |-> (hi_cnt >= 2'd2));
endmodule

bind linelat_pol_ctl linelat_chk #(.NCOL(NCOL), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_stb  (line_stb),
  .col_codes (col_codes),
  .lat_codes (lat_codes),
  .bank_sel  (bank_sel),
  .col_oe    (col_oe)
);

// File: tb/linelat_pol_ctl_tb.sv
module linelat_pol_ctl_tb;
  localparam int NCOL = 8;
  localparam int CW   = 6;
  localparam int DW   = NCOL * CW;
  localparam int TW   = CW + 1;
  localparam int NV   = 6;

  // {strobe width - 2, pol, codes}
  localparam logic [DW+2:0] VEC [NV] = '{
    {2'd0, 1'b0, 48'h000000000000},
    {2'd0, 1'b1, 48'h000000000000},
    {2'd2, 1'b0, 48'hFFFFFFFFFFFF},
    {2'd0, 1'b1, 48'hFFFFFFFFFFFF},
    {2'd1, 1'b0, 48'h0420C4148F3F},
    {2'd2, 1'b1, 48'hFC0F81A5213B}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_stb = 1'b0;
  logic pol_in = 1'b0;
  logic [DW-1:0] col_codes = '0;
  logic [DW-1:0] lat_codes;
  logic [NCOL-1:0] bank_sel;
  logic [NCOL*TW-1:0] ref_tap;
  logic [NCOL-1:0] col_oe;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  linelat_pol_ctl #(.NCOL(NCOL), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .pol_in(pol_in),
    .col_codes(col_codes), .lat_codes(lat_codes), .bank_sel(bank_sel),
    .ref_tap(ref_tap), .col_oe(col_oe)
  );

  function automatic logic [NCOL-1:0] exp_bank(input logic p);
    logic [NCOL-1:0] b;
    for (int c = 0; c < NCOL; c++) b[c] = p ^ ((c % 2) == 1);
    return b;
  endfunction

  function automatic logic [NCOL*TW-1:0] exp_tap(input logic p, input logic [DW-1:0] d);
    logic [NCOL*TW-1:0] t;
    logic [NCOL-1:0] b;
    b = exp_bank(p);
    for (int c = 0; c < NCOL; c++) begin
      if (b[c]) t[c*TW +: TW] = 7'd127 - {1'b0, d[c*CW +: CW]};
      else      t[c*TW +: TW] = {1'b0, d[c*CW +: CW]};
    end
    return t;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One line: strobe high for w clocks, then scramble inputs while low.
  task automatic run_line(input int w, input logic p, input logic [DW-1:0] d);
    @(negedge clk);
    col_codes = d; pol_in = p; line_stb = 1'b1;
    repeat (w) @(negedge clk);
    chk("R1 latch after rise", lat_codes, d);
    chk("R2 outputs off while strobe high", DW'(col_oe), '0);
    col_codes = ~d; pol_in = ~p; line_stb = 1'b0;
    @(negedge clk);
    chk("R3 outputs driven after fall", DW'(col_oe), DW'({NCOL{1'b1}}));
    repeat (2) @(negedge clk);
    chk("R1 latch ignores data while low", lat_codes, d);
    chk("R4 R5 bank from captured polarity", DW'(bank_sel), DW'(exp_bank(p)));
    chk("R6 tap mapping", DW'(ref_tap), DW'(exp_tap(p, d)));
    chk("R3 outputs stay driven", DW'(col_oe), DW'({NCOL{1'b1}}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 oe in reset", DW'(col_oe), '0);
    chk("R8 latch cleared", lat_codes, '0);
    chk("R8 bank pattern", DW'(bank_sel), DW'(8'hAA));
    rst_n = 1'b1;
    col_codes = 48'h123456789ABC; pol_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 oe low before first strobe", DW'(col_oe), '0);
    chk("R8 tap after reset", DW'(ref_tap), DW'(exp_tap(1'b0, '0)));
    chk("R1 no capture without strobe", lat_codes, '0);

    for (int i = 0; i < NV; i++)
      run_line(int'(VEC[i][DW+2:DW+1]) + 2, VEC[i][DW], VEC[i][DW-1:0]);

    // R2: long strobe, sampled mid-pulse
    @(negedge clk);
    col_codes = 48'hA5A5A5A5A5A5; pol_in = 1'b0; line_stb = 1'b1;
    @(negedge clk);
    chk("R2 off first high cycle", DW'(col_oe), '0);
    pol_in = 1'b1; col_codes = '0;
    repeat (3) @(negedge clk);
    chk("R2 off late in pulse", DW'(col_oe), '0);
    chk("R5 polarity change during pulse ignored", DW'(bank_sel), DW'(exp_bank(1'b0)));
    chk("R1 data change during pulse ignored", lat_codes, 48'hA5A5A5A5A5A5);
    line_stb = 1'b0;
    @(negedge clk);
    chk("R3 driven after long pulse", DW'(col_oe), DW'({NCOL{1'b1}}));

    // R8: reset in the middle of a line
    rst_n = 1'b0;
    #1;
    chk("R8 async clear oe", DW'(col_oe), '0);
    chk("R8 async clear latch", lat_codes, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 oe stays off until a pulse", DW'(col_oe), '0);
    run_line(2, 1'b1, 48'h3F000000003F);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule